// File: doc/BRIEF.md
# Bus Interface Unit for a 68000-Style Core

This unit sits between the execution core of a 68000-style soft processor and a 32-bit WISHBONE master port. The core presents one access request at a time: instruction fetch, data read, data write, the locked read-then-write of a test-and-set, or an interrupt acknowledge. The request stays on its inputs until the unit answers. The unit turns it into one or more bus cycles and drives address, byte selects, write data, a cycle-type tag and the registered-feedback cycle qualifiers. It reads the slave's acknowledge, error and retry inputs and gives the core exactly one single-cycle answer: done (with read data), bus error, spurious interrupt, autovector, or retries exhausted.

Memory uses big-endian byte lanes: the lowest-addressed byte travels on data bits 31:24. Byte and word operands move to and from their lanes according to the two low address bits. Longword reads may be issued as incrementing blocks. The same slave response means different things in interrupt-acknowledge cycles and in memory cycles.

Top module: `cpu_wb_biu`

## Requirements
- R1: Writes place the operand on big-endian lanes. With offset o = address bits 1:0, a byte uses select 4'b1000>>o and data bits [31-8o:24-8o]. A word (o = 0, 1 or 2) uses select 4'b1100>>o and is shifted left by 8*(2-o). A longword uses select 4'hF and ignores address bits 1:0.
- R2: Read data is taken from the same lanes as in R1 and returned right-aligned and zero-extended on rsp_rdata together with rsp_done.
- R3: Single accesses drive cycle type 3'b000. A longword fetch or read with req_len = N > 0 issues N+1 beats at consecutive longword addresses, with type 3'b010 and 3'b111 on the last beat. Each non-final beat pulses rsp_beat with its data one cycle after its acknowledge. For every other kind or size, req_len has no effect. The burst type output is always 2'b00.
- R4: Kind codes on req_kind are 0 fetch, 1 read, 2 write, 3 test-and-set, 4 interrupt acknowledge. Sizes on req_size are 0 byte, 1 word, 2 longword. The tag output is 1 for fetch, 0 for read and write, 2 for test-and-set and 3 for interrupt acknowledge.
- R5: An error in a memory cycle ends the access. The next cycle shows rsp_berr with the cycle signal low.
- R6: A retry in a memory cycle removes the strobe for one cycle and then reissues the same beat. Outside the write phase of a test-and-set, the cycle signal is also low for that cycle. After RETRY_MAX retries of one beat, a further retry answers rsp_rfail.
- R7: A test-and-set reads one byte, keeps the cycle signal high with the strobe low for one cycle, then writes that byte with bit 7 set to the same lane. rsp_done returns the original byte.
- R8: An interrupt acknowledge drives a word address of all ones with the pending level in its three low bits, and select 4'b0001. On acknowledge it returns wb_dat_i[7:0] as the vector.
- R9: An error during an interrupt acknowledge answers rsp_spur.
- R10: A retry during an interrupt acknowledge answers rsp_avec and is not reissued.
- R11: During and after reset the cycle, strobe and all response outputs are low.
- R12: Each response is a single-cycle pulse in the cycle after the terminating edge, and at most one response output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until answered |
| req_kind | input | 3 | Access kind (R4) |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Operand size (R4) |
| req_wdata | input | 32 | Right-aligned write operand |
| req_ipl | input | 3 | Interrupt level being acknowledged |
| req_len | input | LEN_W | Extra beats for a longword block read |
| rsp_done | output | 1 | Access completed |
| rsp_berr | output | 1 | Bus error |
| rsp_spur | output | 1 | Spurious interrupt |
| rsp_avec | output | 1 | Use autovector |
| rsp_rfail | output | 1 | Retry limit reached |
| rsp_beat | output | 1 | Block beat data valid |
| rsp_rdata | output | 32 | Read data or vector |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | AW-2 | Longword address |
| wb_sel_o | output | 4 | Byte selects |
| wb_dat_o | output | 32 | Write data |
| wb_cti_o | output | 3 | Cycle type qualifier |
| wb_bte_o | output | 2 | Burst type qualifier |
| wb_tag_o | output | 2 | Access tag |
| wb_ack_i | input | 1 | Acknowledge |
| wb_err_i | input | 1 | Error |
| wb_rty_i | input | 1 | Retry |
| wb_dat_i | input | 32 | Read data |

## Verification
Most state faults reach the bus within one beat. A stale lane offset shows as wrong selects or data. A wrong beat count shows as a wrong cycle type or an extra strobe. A lost test-and-set phase drops the cycle signal between the read and the write. The bench models every access on its own from the requirements and compares each strobed beat, the gap cycle after each retry, and the answer pulse in the single cycle where it must appear. A wrong retry count therefore appears as a missing reissue or an early rsp_rfail, and a mistaken response mapping appears at the first error or retry of that kind.

// File: rtl/cpu_wb_biu.sv
module cpu_wb_biu #(
  parameter int AW        = 32,
  parameter int LEN_W     = 3,
  parameter int RETRY_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic [2:0]       req_ipl,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_done,
  output logic             rsp_berr,
  output logic             rsp_spur,
  output logic             rsp_avec,
  output logic             rsp_rfail,
  output logic             rsp_beat,
  output logic [31:0]      rsp_rdata,
  output logic             wb_cyc_o,
  output logic             wb_stb_o,
  output logic             wb_we_o,
  output logic [AW-3:0]    wb_adr_o,
  output logic [3:0]       wb_sel_o,
  output logic [31:0]      wb_dat_o,
  output logic [2:0]       wb_cti_o,
  output logic [1:0]       wb_bte_o,
  output logic [1:0]       wb_tag_o,
  input  logic             wb_ack_i,
  input  logic             wb_err_i,
  input  logic             wb_rty_i,
  input  logic [31:0]      wb_dat_i
);
  localparam int RW = $clog2(RETRY_MAX + 2);
  localparam logic [2:0] K_FETCH = 3'd0, K_READ = 3'd1, K_WRITE = 3'd2,
                         K_TAS = 3'd3, K_IACK = 3'd4;
  localparam logic [2:0] RES_OK = 3'd0, RES_BERR = 3'd1, RES_SPUR = 3'd2,
                         RES_AVEC = 3'd3, RES_RFAIL = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_BUS, S_MID, S_GAP, S_DONE} st_t;

  st_t              st;
  logic [2:0]       k_q, res_q, ipl_q;
  logic [AW-3:0]    wa_q;
  logic [1:0]       off_q, sz_q;
  logic [31:0]      wd_q, rd_q;
  logic [LEN_W-1:0] len_q, beat_q;
  logic [RW-1:0]    rcnt_q;
  logic             ph_q, bp_q;

  logic             is_iack, is_tas;
  logic [1:0]       pos;
  logic [3:0]       lane_sel;
  logic [4:0]       sh;
  logic [31:0]      wmask, wsrc, rd_ext;

  assign is_iack = (k_q == K_IACK);
  assign is_tas  = (k_q == K_TAS);

  always_comb begin
    case (sz_q)
      2'd0: begin
        lane_sel = 4'b1000 >> off_q;
        pos      = 2'd3 - off_q;
        wmask    = 32'h0000_00FF;
      end
      2'd1: begin
        lane_sel = 4'b1100 >> off_q;
        pos      = (off_q == 2'd3) ? 2'd0 : 2'd2 - off_q;
        wmask    = 32'h0000_FFFF;
      end
      default: begin
        lane_sel = 4'hF;
        pos      = 2'd0;
        wmask    = 32'hFFFF_FFFF;
      end
    endcase
  end

  assign sh     = {pos, 3'b000};
  assign wsrc   = is_tas ? {24'd0, rd_q[7:0] | 8'h80} : wd_q;
  assign rd_ext = (wb_dat_i >> sh) & wmask;

  assign wb_cyc_o = (st == S_BUS) || (st == S_MID);
  assign wb_stb_o = (st == S_BUS);
  assign wb_we_o  = (st == S_BUS) && ((k_q == K_WRITE) || (is_tas && ph_q));
  assign wb_adr_o = is_iack ? {{(AW-5){1'b1}}, ipl_q} : wa_q;
  assign wb_sel_o = is_iack ? 4'b0001 : lane_sel;
  assign wb_dat_o = (wsrc & wmask) << sh;
  assign wb_cti_o = (len_q == '0) ? 3'b000 : ((beat_q == len_q) ? 3'b111 : 3'b010);
  assign wb_bte_o = 2'b00;
  assign wb_tag_o = is_iack ? 2'd3 : is_tas ? 2'd2 : (k_q == K_FETCH) ? 2'd1 : 2'd0;

  assign rsp_done  = (st == S_DONE) && (res_q == RES_OK);
  assign rsp_berr  = (st == S_DONE) && (res_q == RES_BERR);
  assign rsp_spur  = (st == S_DONE) && (res_q == RES_SPUR);
  assign rsp_avec  = (st == S_DONE) && (res_q == RES_AVEC);
  assign rsp_rfail = (st == S_DONE) && (res_q == RES_RFAIL);
  assign rsp_beat  = bp_q;
  assign rsp_rdata = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      k_q    <= K_READ;
      res_q  <= RES_OK;
      ipl_q  <= '0;
      wa_q   <= '0;
      off_q  <= '0;
      sz_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      len_q  <= '0;
      beat_q <= '0;
      rcnt_q <= '0;
      ph_q   <= 1'b0;
      bp_q   <= 1'b0;
    end else begin
      bp_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          k_q    <= req_kind;
          wa_q   <= req_addr[AW-1:2];
          sz_q   <= (req_kind == K_TAS) ? 2'd0 : req_size;
          off_q  <= (req_size == 2'd2 && req_kind != K_TAS) ? 2'd0 : req_addr[1:0];
          wd_q   <= req_wdata;
          ipl_q  <= req_ipl;
          len_q  <= ((req_kind == K_FETCH || req_kind == K_READ) && req_size == 2'd2)
                    ? req_len : '0;
          beat_q <= '0;
          rcnt_q <= '0;
          ph_q   <= 1'b0;
          res_q  <= RES_OK;
          st     <= S_BUS;
        end
        S_BUS: begin
          if (wb_err_i) begin
            res_q <= is_iack ? RES_SPUR : RES_BERR;
            st    <= S_DONE;
          end else if (wb_rty_i) begin
            if (is_iack) begin
              res_q <= RES_AVEC;
              st    <= S_DONE;
            end else if (rcnt_q == RW'(RETRY_MAX)) begin
              res_q <= RES_RFAIL;
              st    <= S_DONE;
            end else begin
              rcnt_q <= rcnt_q + 1'b1;
              st     <= (is_tas && ph_q) ? S_MID : S_GAP;
            end
          end else if (wb_ack_i) begin
            rcnt_q <= '0;
            if (is_iack) begin
              rd_q <= {24'd0, wb_dat_i[7:0]};
              st   <= S_DONE;
            end else if (is_tas && !ph_q) begin
              rd_q <= rd_ext;
              ph_q <= 1'b1;
              st   <= S_MID;
            end else if (is_tas) begin
              st <= S_DONE;
            end else if (beat_q != len_q) begin
              rd_q   <= rd_ext;
              bp_q   <= 1'b1;
              beat_q <= beat_q + 1'b1;
              wa_q   <= wa_q + 1'b1;
            end else begin
              rd_q <= rd_ext;
              st   <= S_DONE;
            end
          end
        end
        S_MID:   st <= S_BUS;
        S_GAP:   st <= S_BUS;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_err_i && wb_tag_o != 2'd3) |=> (rsp_berr && !wb_cyc_o));

  assert_retry_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_rty_i && !wb_err_i && wb_tag_o != 2'd3) |=> !wb_stb_o);

  assert_rmw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_we_o && wb_tag_o == 2'd2 && wb_ack_i && !wb_err_i && !wb_rty_i)
    |=> (wb_cyc_o && !wb_stb_o));

  assert_iack_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_err_i && wb_tag_o == 2'd3) |=> rsp_spur);

  assert_iack_rty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && wb_rty_i && !wb_err_i && wb_tag_o == 2'd3) |=> (rsp_avec && !wb_stb_o));

  assert_one_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail}) <= 1);
endmodule

// File: tb/cpu_wb_biu_test.sv
module cpu_wb_biu_test;
  localparam int RM = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_kind = 0, req_ipl = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_size = 0;
  logic [2:0] req_len = 0;
  logic rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail, rsp_beat;
  logic [31:0] rsp_rdata;
  logic wb_cyc_o, wb_stb_o, wb_we_o;
  logic [29:0] wb_adr_o;
  logic [3:0] wb_sel_o;
  logic [31:0] wb_dat_o;
  logic [2:0] wb_cti_o;
  logic [1:0] wb_bte_o, wb_tag_o;
  logic wb_ack_i = 0, wb_err_i = 0, wb_rty_i = 0;
  logic [31:0] wb_dat_i = 0;

  int errors = 0, checks = 0;
  bit finished = 0;
  int rq[$];

  always #5 clk = ~clk;

  cpu_wb_biu #(.AW(32), .LEN_W(3), .RETRY_MAX(RM)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] lanes_out(input logic [31:0] v, input int sz, input int off);
    if (sz == 0) return (v & 32'hFF) << (8 * (3 - off));
    if (sz == 1) return (v & 32'hFFFF) << (8 * (2 - off));
    return v;
  endfunction

  function automatic logic [31:0] lanes_in(input logic [31:0] d, input int sz, input int off);
    if (sz == 0) return (d >> (8 * (3 - off))) & 32'hFF;
    if (sz == 1) return (d >> (8 * (2 - off))) & 32'hFFFF;
    return d;
  endfunction

  function automatic logic [3:0] sel_of(input int sz, input int off);
    if (sz == 0) return 4'b1000 >> off;
    if (sz == 1) return 4'b1100 >> off;
    return 4'hF;
  endfunction

  // exp_res: 0 done, 1 berr, 2 spur, 3 avec, 4 rfail
  task automatic run(input int kind, input logic [31:0] addr, input int size,
                     input logic [31:0] wdata, input int ipl, input int len, input string rtag);
    int sz = (kind == 3) ? 0 : size;
    int off = (sz == 2) ? 0 : int'(addr[1:0]);
    int blen = ((kind == 0 || kind == 1) && size == 2) ? len : 0;
    logic [29:0] wa = addr[31:2];
    logic [1:0] tag = (kind == 4) ? 2'd3 : (kind == 3) ? 2'd2 : (kind == 0) ? 2'd1 : 2'd0;
    int k = 0, ph = 0, rc = 0, exp_res = 0, wd = 0;
    bit fin = 0, pend = 0, gapchk = 0, midchk = 0;
    logic [31:0] exp_data = 0, beat_dat = 0, orig = 0;
    @(negedge clk);
    req_kind = 3'(kind); req_addr = addr; req_size = 2'(size);
    req_wdata = wdata; req_ipl = 3'(ipl); req_len = 3'(len); req_valid = 1;
    forever begin
      @(negedge clk);
      wd++;
      if (wd > 300) begin
        chk(0, {rtag, " watchdog"}, 0, 1);
        break;
      end
      if (pend) begin
        chk(rsp_beat && rsp_rdata == beat_dat, "R3 beat data", {31'd0, rsp_beat, rsp_rdata}, {32'd1, beat_dat});
        pend = 0;
      end
      if (gapchk) begin
        chk(!wb_cyc_o && !wb_stb_o, "R6 retry gap", {wb_cyc_o, wb_stb_o}, 0);
        gapchk = 0;
      end
      if (midchk) begin
        chk(wb_cyc_o && !wb_stb_o, "R7 locked gap", {wb_cyc_o, wb_stb_o}, 2'b10);
        midchk = 0;
      end
      if (fin) begin
        logic [4:0] got = {rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail};
        logic [4:0] ex = 5'b10000 >> exp_res;
        chk(got == ex, {rtag, " response"}, got, ex);
        if (exp_res == 0 && kind != 2)
          chk(rsp_rdata == exp_data, {rtag, " read data"}, rsp_rdata, exp_data);
        wb_ack_i = 0; wb_err_i = 0; wb_rty_i = 0;
        req_valid = 0;
        @(negedge clk);
        chk({rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail, wb_cyc_o} == 0,
            "R12 single pulse", {rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail, wb_cyc_o}, 0);
        break;
      end
      if ({rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail} != 0)
        chk(0, "R12 early response", {rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail}, 0);
      if (wb_stb_o) begin
        logic [29:0] ea = (kind == 4) ? {27'h7FF_FFFF, 3'(ipl)} : wa;
        logic [3:0] es = (kind == 4) ? 4'b0001 : sel_of(sz, off);
        logic ew = (kind == 2) || (kind == 3 && ph == 1);
        logic [2:0] ec = (blen == 0) ? 3'b000 : (k == blen) ? 3'b111 : 3'b010;
        logic [31:0] ed = (kind == 3) ? lanes_out(orig | 32'h80, 0, off) : lanes_out(wdata, sz, off);
        logic [31:0] d = f(ea);
        int r = (rq.size() > 0) ? rq.pop_front() : 0;
        bit ok = (wb_adr_o == ea) && (wb_sel_o == es) && (wb_we_o == ew) && (wb_cti_o == ec)
                 && (wb_tag_o == tag) && (wb_bte_o == 2'b00) && wb_cyc_o && (!ew || wb_dat_o == ed);
        chk(ok, {rtag, " bus beat R1 R3 R4"},
            {wb_adr_o, wb_sel_o, wb_we_o, wb_cti_o, wb_tag_o, wb_dat_o[23:0]},
            {ea, es, ew, ec, tag, ed[23:0]});
        wb_dat_i = d;
        wb_ack_i = (r == 0); wb_err_i = (r == 1); wb_rty_i = (r == 2);
        if (r == 1) begin
          fin = 1; exp_res = (kind == 4) ? 2 : 1;
        end else if (r == 2) begin
          if (kind == 4) begin fin = 1; exp_res = 3; end
          else if (rc == RM) begin fin = 1; exp_res = 4; end
          else begin
            rc++;
            if (kind == 3 && ph == 1) midchk = 1; else gapchk = 1;
          end
        end else begin
          rc = 0;
          if (kind == 4) begin fin = 1; exp_data = {24'd0, d[7:0]}; end
          else if (kind == 3 && ph == 0) begin orig = lanes_in(d, 0, off); ph = 1; midchk = 1; end
          else if (kind == 3) begin fin = 1; exp_data = orig; end
          else if (k < blen) begin pend = 1; beat_dat = d; k++; wa = wa + 1'b1; end
          else begin fin = 1; exp_data = lanes_in(d, sz, off); end
        end
      end else begin
        wb_ack_i = 0; wb_err_i = 0; wb_rty_i = 0;
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({wb_cyc_o, wb_stb_o, rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail, rsp_beat} == 0,
        "R11 in reset", {wb_cyc_o, wb_stb_o, rsp_done, rsp_berr, rsp_spur, rsp_avec, rsp_rfail, rsp_beat}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({wb_cyc_o, wb_stb_o, rsp_done, rsp_berr} == 0, "R11 after reset",
        {wb_cyc_o, wb_stb_o, rsp_done, rsp_berr}, 0);

    rq = {};     run(1, 32'h0000_0100, 2, 0, 0, 0, "R2 long read");
    rq = {};     run(0, 32'h0000_0202, 1, 0, 0, 0, "R2 word fetch off2");
    rq = {};     run(1, 32'h0000_0301, 0, 0, 0, 0, "R2 byte read off1");
    rq = {};     run(1, 32'h0000_0311, 1, 0, 0, 0, "R2 word read off1");
    rq = {};     run(2, 32'h0000_0403, 0, 32'h1234_56AB, 0, 0, "R1 byte write off3");
    rq = {};     run(2, 32'h0000_0400, 0, 32'h0000_00CD, 0, 0, "R1 byte write off0");
    rq = {};     run(2, 32'h0000_0501, 1, 32'h9999_BEEF, 0, 0, "R1 word write off1");
    rq = {};     run(2, 32'h0000_0603, 2, 32'hCAFE_F00D, 0, 3, "R1 R3 long write len ignored");
    rq = {};     run(1, 32'h0000_0612, 1, 0, 0, 3, "R3 word read len ignored");
    rq = {};     run(1, 32'h0000_0700, 2, 0, 0, 3, "R3 block read");
    rq = {0, 2, 0, 0}; run(0, 32'h0000_0800, 2, 0, 0, 2, "R6 block fetch retry");
    rq = {1};    run(1, 32'h0000_0900, 2, 0, 0, 0, "R5 read error");
    rq = {0, 1}; run(1, 32'h0000_0A00, 2, 0, 0, 3, "R5 block error");
    rq = {1};    run(2, 32'h0000_0A10, 1, 32'h55AA, 0, 0, "R5 write error");
    rq = {2, 0}; run(1, 32'h0000_0B02, 1, 0, 0, 0, "R6 retry then ack");
    rq = {2, 2, 2, 2}; run(2, 32'h0000_0C00, 2, 32'h0102_0304, 0, 0, "R6 retries exhausted");
    rq = {};     run(3, 32'h0000_0D05, 0, 0, 0, 0, "R7 test-and-set");
    rq = {0, 2, 0}; run(3, 32'h0000_0E02, 0, 0, 0, 0, "R7 test-and-set write retry");
    rq = {2, 0, 0}; run(3, 32'h0000_0E13, 0, 0, 0, 0, "R7 test-and-set read retry");
    rq = {};     run(4, 0, 0, 0, 5, 0, "R8 interrupt acknowledge");
    rq = {};     run(4, 0, 0, 0, 1, 0, "R8 interrupt acknowledge level1");
    rq = {1};    run(4, 0, 0, 0, 6, 0, "R9 spurious");
    rq = {2};    run(4, 0, 0, 0, 3, 0, "R10 autovector");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule